// File: doc/BRIEF.md
# Bit-Reversed Byte/Word Packer

This block converts a byte stream into 16-bit words for a shared-memory data buffer, and converts such words back into bytes. On the pack side each byte is mirrored end to end, so that its bit 0 becomes bit 7. The first byte of a pair then lands in the upper half of the word and the second byte in the lower half. A flush input closes a stream that has an odd number of bytes. The last byte then goes out alone, with a zero lower half, and a flag marks that word as half filled.

The unpack side handles a receive stream. It is first given the total byte count. It then takes one word at a time and returns the upper half and then the lower half, each mirrored back to normal bit order. When only one byte of the count remains, the lower half of the final word is dropped. Both sides use valid/ready handshakes. A stalled output holds its data and blocks further intake without losing anything already taken in.

The pack engine has three states:
- `PK_EMPTY` goes to `PK_HOLD_HI` on a byte, or to `PK_FULL` on a byte presented together with flush.
- `PK_HOLD_HI` goes to `PK_FULL` on a byte or on flush.
- `PK_FULL` goes back to `PK_EMPTY` when the word is taken.

The unpack engine has four states:
- `UP_IDLE` goes to `UP_WAIT` on a start with a non-zero count.
- `UP_WAIT` goes to `UP_EMIT_HI` when a word is accepted.
- `UP_EMIT_HI` goes to `UP_EMIT_LO`, or to `UP_IDLE` if it just sent the last byte.
- `UP_EMIT_LO` goes to `UP_WAIT`, or to `UP_IDLE` if it just sent the last byte.

Top module: `revpack_top`

## Requirements
- R1: During and directly after reset, `pk_out_valid`, `up_out_valid` and `up_in_ready` are 0 and `pk_in_ready` is 1.
- R2: A packed word holds the bit-mirrored first byte in bits 15:8 and the bit-mirrored second byte in bits 7:0. For example, the bytes 0xCD then 0xAB give 0xB3D5.
- R3: The cycle after the second byte of a pair is accepted, `pk_out_valid` is 1 and `pk_out_half` is 0.
- R4: Flush with one byte pending, or a lone first byte presented together with flush, gives the word {mirrored byte, 0x00} with `pk_out_half` = 1. A second byte presented together with flush completes a full pair with `pk_out_half` = 0.
- R5: Flush with no byte pending and no byte presented produces no output word.
- R6: While `pk_out_valid` is 1 and `pk_out_ready` is 0, the word and flag hold steady and `pk_in_ready` is 0. A byte offered during the stall is accepted afterwards and appears in the next word.
- R7: After a start with count N > 0, the unpacker accepts one word at a time. It emits the mirrored bits 15:8 first and then the mirrored bits 7:0.
- R8: `up_out_last` is 1 exactly on byte N. For an odd N the lower half of the final word is never emitted. After byte N, and at once for N = 0, `up_out_valid` and `up_in_ready` are 0.
- R9: While `up_out_valid` is 1 and `up_out_ready` is 0, the byte and last flag hold and `up_in_ready` is 0.
- R10: A start pulse while an unpack run is in progress is ignored, and the run ends after its original count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pk_in_valid | input | 1 | Byte offered to the packer |
| pk_in_byte | input | 8 | Byte value |
| pk_in_ready | output | 1 | Packer can take a byte |
| pk_flush | input | 1 | Close the stream; any pending single byte goes out |
| pk_out_valid | output | 1 | Packed word available |
| pk_out_word | output | 16 | Packed word |
| pk_out_half | output | 1 | Word carries only an upper byte |
| pk_out_ready | input | 1 | Consumer takes the packed word |
| up_start | input | 1 | Begin an unpack run (ignored unless idle) |
| up_count | input | 10 | Total bytes in the run |
| up_in_valid | input | 1 | Word offered to the unpacker |
| up_in_word | input | 16 | Packed word |
| up_in_ready | output | 1 | Unpacker can take a word |
| up_out_valid | output | 1 | Unpacked byte available |
| up_out_byte | output | 8 | Unpacked byte in normal bit order |
| up_out_last | output | 1 | This byte is the last of the run |
| up_out_ready | input | 1 | Consumer takes the byte |

## Verification
The assertions assume that sources keep their valid and data steady until the handshake completes. They also assume that `up_in_valid` is raised only while a run is open. The bench drives every input on the falling edge and holds each offer until `pk_in_ready` or `up_in_ready` is seen high. It feeds no more words than the announced count needs. Start pulses outside the idle state are issued on purpose, since the block must ignore them.

// File: rtl/revpack_pkg.sv
package revpack_pkg;
    localparam int unsigned RP_BYTE_W = 8;
    localparam int unsigned RP_CNT_W  = 10;

    typedef enum logic [1:0] {
        PK_EMPTY,
        PK_HOLD_HI,
        PK_FULL
    } pk_state_e;

    typedef enum logic [1:0] {
        UP_IDLE,
        UP_WAIT,
        UP_EMIT_HI,
        UP_EMIT_LO
    } up_state_e;
endpackage

// File: rtl/revpack_bitrev.sv
module revpack_bitrev #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[W-1-i];
    end
endmodule

// File: rtl/revpack_packer.sv
module revpack_packer
    import revpack_pkg::*;
#(
    parameter  int unsigned BYTE_W = RP_BYTE_W,
    localparam int unsigned WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    input  logic              flush,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              out_half,
    input  logic              out_ready
);
    localparam logic [BYTE_W-1:0] ZERO_B = '0;

    pk_state_e         state, state_d;
    logic [BYTE_W-1:0] hi_q;
    logic [WORD_W-1:0] word_q;
    logic              half_q;
    logic [BYTE_W-1:0] rev_byte;

    revpack_bitrev #(.W(BYTE_W)) u_rev (.din(in_byte), .dout(rev_byte));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PK_EMPTY;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            PK_EMPTY:   if (in_valid) state_d = flush ? PK_FULL : PK_HOLD_HI;
            PK_HOLD_HI: if (in_valid || flush) state_d = PK_FULL;
            PK_FULL:    if (out_ready) state_d = PK_EMPTY;
            default:    state_d = PK_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            word_q <= '0;
            half_q <= 1'b0;
        end else begin
            unique case (state)
                PK_EMPTY: begin
                    if (in_valid) begin
                        hi_q <= rev_byte;
                        if (flush) begin
                            word_q <= {rev_byte, ZERO_B};
                            half_q <= 1'b1;
                        end
                    end
                end
                PK_HOLD_HI: begin
                    if (in_valid) begin
                        word_q <= {hi_q, rev_byte};
                        half_q <= 1'b0;
                    end else if (flush) begin
                        word_q <= {hi_q, ZERO_B};
                        half_q <= 1'b1;
                    end
                end
                PK_FULL: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        in_ready  = 1'b1;
        out_valid = 1'b0;
        unique case (state)
            PK_EMPTY, PK_HOLD_HI: ;
            PK_FULL: begin
                in_ready  = 1'b0;
                out_valid = 1'b1;
            end
            default: ;
        endcase
        out_word = word_q;
        out_half = half_q;
    end

    AST_PK_PAIR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PK_HOLD_HI && in_valid) |=> (out_valid && !out_half)); // R3
    AST_PK_HALF_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_half) |-> (out_word[BYTE_W-1:0] == ZERO_B)); // R4
    AST_PK_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PK_EMPTY && flush && !in_valid) |=> !out_valid); // R5
    AST_PK_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_half))); // R6
    AST_PK_NO_INTAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R6
endmodule

// File: rtl/revpack_unpacker.sv
module revpack_unpacker
    import revpack_pkg::*;
#(
    parameter  int unsigned BYTE_W = RP_BYTE_W,
    parameter  int unsigned CNT_W  = RP_CNT_W,
    localparam int unsigned WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  count,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_last,
    input  logic              out_ready
);
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] NONE = '0;

    up_state_e         state, state_d;
    logic [CNT_W-1:0]  rem_q;
    logic [WORD_W-1:0] word_q;
    logic [BYTE_W-1:0] rev_hi, rev_lo;

    revpack_bitrev #(.W(BYTE_W)) u_rev_hi (.din(word_q[WORD_W-1:BYTE_W]), .dout(rev_hi));
    revpack_bitrev #(.W(BYTE_W)) u_rev_lo (.din(word_q[BYTE_W-1:0]),      .dout(rev_lo));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= UP_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            UP_IDLE:    if (start && count != NONE) state_d = UP_WAIT;
            UP_WAIT:    if (in_valid) state_d = UP_EMIT_HI;
            UP_EMIT_HI: if (out_ready) state_d = (rem_q == ONE) ? UP_IDLE : UP_EMIT_LO;
            UP_EMIT_LO: if (out_ready) state_d = (rem_q == ONE) ? UP_IDLE : UP_WAIT;
            default:    state_d = UP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            word_q <= '0;
        end else begin
            unique case (state)
                UP_IDLE:                if (start) rem_q <= count;
                UP_WAIT:                if (in_valid) word_q <= in_word;
                UP_EMIT_HI, UP_EMIT_LO: if (out_ready) rem_q <= rem_q - ONE;
                default: ;
            endcase
        end
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_byte  = rev_hi;
        out_last  = 1'b0;
        unique case (state)
            UP_IDLE: ;
            UP_WAIT: in_ready = 1'b1;
            UP_EMIT_HI: begin
                out_valid = 1'b1;
                out_last  = (rem_q == ONE);
            end
            UP_EMIT_LO: begin
                out_valid = 1'b1;
                out_byte  = rev_lo;
                out_last  = (rem_q == ONE);
            end
            default: ;
        endcase
    end

    AST_UP_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && !in_ready)); // R8
    AST_UP_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last))); // R9
    AST_UP_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R9
    AST_UP_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != UP_IDLE && !(out_valid && out_ready)) |=> $stable(rem_q)); // R10
endmodule

// File: rtl/revpack_top.sv
module revpack_top
    import revpack_pkg::*;
#(
    parameter  int unsigned BYTE_W = RP_BYTE_W,
    parameter  int unsigned CNT_W  = RP_CNT_W,
    localparam int unsigned WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pk_in_valid,
    input  logic [BYTE_W-1:0] pk_in_byte,
    output logic              pk_in_ready,
    input  logic              pk_flush,
    output logic              pk_out_valid,
    output logic [WORD_W-1:0] pk_out_word,
    output logic              pk_out_half,
    input  logic              pk_out_ready,
    input  logic              up_start,
    input  logic [CNT_W-1:0]  up_count,
    input  logic              up_in_valid,
    input  logic [WORD_W-1:0] up_in_word,
    output logic              up_in_ready,
    output logic              up_out_valid,
    output logic [BYTE_W-1:0] up_out_byte,
    output logic              up_out_last,
    input  logic              up_out_ready
);
    revpack_packer #(.BYTE_W(BYTE_W)) u_pack (
        .clk, .rst_n,
        .in_valid(pk_in_valid), .in_byte(pk_in_byte), .in_ready(pk_in_ready),
        .flush(pk_flush),
        .out_valid(pk_out_valid), .out_word(pk_out_word), .out_half(pk_out_half),
        .out_ready(pk_out_ready)
    );

    revpack_unpacker #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_unpack (
        .clk, .rst_n,
        .start(up_start), .count(up_count),
        .in_valid(up_in_valid), .in_word(up_in_word), .in_ready(up_in_ready),
        .out_valid(up_out_valid), .out_byte(up_out_byte), .out_last(up_out_last),
        .out_ready(up_out_ready)
    );

    AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |->
        (!pk_out_valid && pk_in_ready && !up_out_valid && !up_in_ready)); // R1
endmodule

// File: tb/revpack_top_tb.sv
`timescale 1ns/1ps
module revpack_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pk_in_valid = 1'b0;
    logic [7:0]  pk_in_byte = '0;
    logic        pk_in_ready;
    logic        pk_flush = 1'b0;
    logic        pk_out_valid;
    logic [15:0] pk_out_word;
    logic        pk_out_half;
    logic        pk_out_ready = 1'b0;
    logic        up_start = 1'b0;
    logic [9:0]  up_count = '0;
    logic        up_in_valid = 1'b0;
    logic [15:0] up_in_word = '0;
    logic        up_in_ready;
    logic        up_out_valid;
    logic [7:0]  up_out_byte;
    logic        up_out_last;
    logic        up_out_ready = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    revpack_top u_dut (.*);

    function automatic logic [7:0] rv(input logic [7:0] b);
        logic [7:0] r = 8'd0;
        for (int i = 0; i < 8; i++) if (b[i]) r = r + (8'd1 << (7 - i));
        return r;
    endfunction

    function automatic logic [7:0] pb(input int i);
        return 8'((i * 29 + 5) & 255);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic fl);
        pk_in_valid = 1'b1; pk_in_byte = b; pk_flush = fl;
        while (!pk_in_ready) @(negedge clk);
        @(negedge clk);
        pk_in_valid = 1'b0; pk_flush = 1'b0;
    endtask

    task automatic take_word();
        pk_out_ready = 1'b1;
        @(negedge clk);
        pk_out_ready = 1'b0;
    endtask

    task automatic pack_pair(input logic [7:0] a, input logic [7:0] b, input logic fl);
        send_byte(a, 1'b0);
        send_byte(b, fl);
        chk("R3 valid", 32'(pk_out_valid), 32'd1);
        chk("R2 word", 32'(pk_out_word), 32'({rv(a), rv(b)}));
        chk(fl ? "R4 half" : "R3 half", 32'(pk_out_half), 32'd0);
        take_word();
    endtask

    task automatic unpack_run(input int n, input bit glitch);
        up_start = 1'b1; up_count = 10'(n);
        @(negedge clk);
        up_start = 1'b0;
        if (n == 0) begin
            chk("R8 zero ready", 32'(up_in_ready), 32'd0);
            chk("R8 zero valid", 32'(up_out_valid), 32'd0);
            return;
        end
        for (int k = 0; k < n; k += 2) begin
            up_in_valid = 1'b1; up_in_word = {rv(pb(k)), rv(pb(k + 1))};
            while (!up_in_ready) @(negedge clk);
            @(negedge clk);
            up_in_valid = 1'b0;
            chk("R7 hi valid", 32'(up_out_valid), 32'd1);
            chk("R7 hi byte", 32'(up_out_byte), 32'(pb(k)));
            chk(glitch ? "R10 hi last" : "R8 hi last", 32'(up_out_last), 32'(k == n - 1));
            if (k == 0) begin
                for (int h = 0; h < 2; h++) begin
                    if (glitch) begin up_start = 1'b1; up_count = 10'd1; end
                    @(negedge clk);
                    up_start = 1'b0;
                    chk("R9 hold valid", 32'(up_out_valid), 32'd1);
                    chk("R9 hold byte", 32'(up_out_byte), 32'(pb(k)));
                    chk("R9 no intake", 32'(up_in_ready), 32'd0);
                end
            end
            up_out_ready = 1'b1; @(negedge clk); up_out_ready = 1'b0;
            if (k + 1 < n) begin
                chk("R7 lo valid", 32'(up_out_valid), 32'd1);
                chk("R7 lo byte", 32'(up_out_byte), 32'(pb(k + 1)));
                chk(glitch ? "R10 lo last" : "R8 lo last", 32'(up_out_last), 32'(k + 1 == n - 1));
                up_out_ready = 1'b1; @(negedge clk); up_out_ready = 1'b0;
            end
        end
        chk("R8 end valid", 32'(up_out_valid), 32'd0);
        chk("R8 end ready", 32'(up_in_ready), 32'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        chk("R1 pk valid", 32'(pk_out_valid), 32'd0);
        chk("R1 pk ready", 32'(pk_in_ready), 32'd1);
        chk("R1 up valid", 32'(up_out_valid), 32'd0);
        chk("R1 up ready", 32'(up_in_ready), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 worked example
        pack_pair(8'hCD, 8'hAB, 1'b0);
        chk("R2 example", 32'({rv(8'hCD), rv(8'hAB)}), 32'hB3D5);

        // R2 R3 sweep of every first byte
        for (int a = 0; a < 256; a++) pack_pair(8'(a), 8'((a * 113 + 7) & 255), 1'b0);

        // R4 half words, flush alone or with the byte
        for (int a = 0; a < 256; a++) begin
            if (a % 2 == 0) begin
                send_byte(8'(a), 1'b0);
                pk_flush = 1'b1; @(negedge clk); pk_flush = 1'b0;
            end else begin
                send_byte(8'(a), 1'b1);
            end
            chk("R4 valid", 32'(pk_out_valid), 32'd1);
            chk("R4 word", 32'(pk_out_word), 32'({rv(8'(a)), 8'h00}));
            chk("R4 half", 32'(pk_out_half), 32'd1);
            take_word();
        end
        // R4 flush with the second byte completes a full pair
        for (int a = 0; a < 16; a++) pack_pair(8'(a * 17), 8'(255 - a), 1'b1);

        // R5 flush with nothing pending
        pk_flush = 1'b1; @(negedge clk); pk_flush = 1'b0;
        chk("R5 no word", 32'(pk_out_valid), 32'd0);
        @(negedge clk);
        chk("R5 no word later", 32'(pk_out_valid), 32'd0);
        chk("R5 ready", 32'(pk_in_ready), 32'd1);
        pack_pair(8'h12, 8'h34, 1'b0);

        // R6 back-pressure
        send_byte(8'h81, 1'b0);
        send_byte(8'h3C, 1'b0);
        held = pk_out_word;
        pk_in_valid = 1'b1; pk_in_byte = 8'hE1;
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            chk("R6 hold valid", 32'(pk_out_valid), 32'd1);
            chk("R6 hold word", 32'(pk_out_word), 32'(held));
            chk("R6 no intake", 32'(pk_in_ready), 32'd0);
        end
        chk("R6 held value", 32'(held), 32'({rv(8'h81), rv(8'h3C)}));
        pk_out_ready = 1'b1; @(negedge clk); pk_out_ready = 1'b0;
        chk("R6 ready again", 32'(pk_in_ready), 32'd1);
        @(negedge clk);
        pk_in_valid = 1'b0;
        send_byte(8'h07, 1'b0);
        chk("R6 kept byte", 32'(pk_out_word), 32'({rv(8'hE1), rv(8'h07)}));
        take_word();

        // R7 R8 R9 R10 unpack runs
        for (int n = 0; n < 10; n++) unpack_run(n, n == 5);
        unpack_run(256, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule